// File: doc/BRIEF.md
# Programmable Horizontal Sync Generator

This block turns a pixel clock into the horizontal timing of a raster display: an active-low horizontal blank, an active-low horizontal sync, a one-clock strobe at the start of every line and a one-clock strobe at the middle of every line. Downstream vertical and composite-sync logic use the two strobes to step their line counters and to place serration and equalization pulses.

Timing is set by four static values, each an absolute position on a pixel counter. The counter holds the value 1 during reset, keeps it for the first clock edge after reset is released, and then runs 1, 2, ... up to the line total before returning to 1. `porch_pos` ends the front porch and starts sync. `sync_pos` ends sync. `blank_pos` ends blanking. `line_len` is the line total. With the interlace select high, the line total is halved internally, so the line-start strobe runs at twice the line rate. All outputs are registered on the falling clock edge.

Top module: `hsync_timing_gen`

## Requirements
- R1: The pixel counter counts 1, 2, ..., P and then returns to 1, where P is the effective line total (P >= 2). The line period is therefore P clocks.
- R2: `hblank_n` is 0 while the count is in 1 .. `blank_pos`-1 and 1 otherwise, so blanking lasts `blank_pos`-1 clocks and begins at count 1.
- R3: `hsync_n` is 0 while the count is in `porch_pos` .. `sync_pos`-1 and 1 otherwise, so sync lasts `sync_pos`-`porch_pos` clocks.
- R4: The front porch runs over counts 1 .. `porch_pos`-1. During it `hblank_n` is 0 and `hsync_n` is 1, so it lasts `porch_pos`-1 clocks.
- R5: All four outputs change only on the falling clock edge. A value decoded from a count first appears half a clock after the rising edge that produced that count.
- R6: With `interlace` = 1, P = `line_len` >> 1 (integer halving). With `interlace` = 0, P = `line_len`.
- R7: `line_stb` is 1 for exactly the clock at count 1. `half_stb` is 1 for exactly the clock at count (P >> 1) + 1. The two strobes are never 1 together.
- R8: While `rst_n` = 0 at a rising edge, the counter is held at 1 and, from the following falling edge, `hblank_n` = `hsync_n` = 1 and both strobes are 0. The first rising edge with `rst_n` = 1 is clock edge 1, and the count 1 decoded from it appears at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| interlace | input | 1 | 1 halves the line total |
| porch_pos | input | CW | Count at which the front porch ends and sync starts |
| sync_pos | input | CW | Count at which sync ends |
| blank_pos | input | CW | Count at which blanking ends |
| line_len | input | CW | Line total in clocks |
| hblank_n | output | 1 | Horizontal blank, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| line_stb | output | 1 | One-clock strobe at count 1 |
| half_stb | output | 1 | One-clock strobe at mid-line |

## Verification
A count is set by a rising edge and its decoded outputs are registered on the next falling edge, so each result is due half a clock after the edge that produced it. The bench samples every output twice per cycle. The first sample, 1 ns after the rising edge, must still show the value for the previous count, or the idle reset levels just after reset release. The second sample, 1 ns after the falling edge, must show the value for the new count. Expected values come from the count ((k-1) mod P)+1 at edge k after release, for several interlaced and non-interlaced configurations, each swept over more than two full lines.

// File: rtl/hs_pkg.sv
// Shared width for the horizontal timing block.
// Assumes: every position value fits in CW bits.
package hs_pkg;
    parameter int unsigned HS_CW = 12;
    typedef logic [HS_CW-1:0] hs_count_t;
endpackage

// File: rtl/hs_line_counter.sv
// Pixel counter for one line. It runs 1..P and wraps to 1, with P = line_len,
// or line_len/2 when interlace is set. It also gives the mid-line position.
// Assumes: the effective total is at least 2 and stays constant while running.
module hs_line_counter #(
    parameter int unsigned CW = hs_pkg::HS_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          interlace,
    input  logic [CW-1:0] line_len,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] eff_len,
    output logic [CW-1:0] mid_pos,
    output logic          run_q
);
    logic [CW-1:0] cnt_next;

    // Effective line total and the mid-line position.
    always_comb begin
        eff_len = interlace ? (line_len >> 1) : line_len;
        mid_pos = (eff_len >> 1) + CW'(1);
    end

    // Next count value, wrapping after the total.
    always_comb begin
        cnt_next = (cnt >= eff_len) ? CW'(1) : cnt + CW'(1);
    end

    // Run flag. The first edge after reset keeps count 1.
    always_ff @(posedge clk) begin
        run_q <= rst_n;
    end

    // Counter register, held at 1 in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= CW'(1);
        else if (run_q) cnt <= cnt_next;
    end

    // R8: reset holds the counter at 1
    a_r8_hold_one: assert property (@(posedge clk) !rst_n |=> cnt == CW'(1));
    // R1: wrap back to 1 after the total
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt == eff_len) |=> cnt == CW'(1));
    // R1: count stays within 1..P
    a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_len >= CW'(2)) |-> (cnt >= CW'(1) && cnt <= eff_len));
endmodule

// File: rtl/hs_edge_decode.sv
// Compares the count with the programmed positions and registers the outputs
// on the falling clock edge.
// Assumes: the positions are static while running.
module hs_edge_decode #(
    parameter int unsigned CW = hs_pkg::HS_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_q,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] mid_pos,
    input  logic [CW-1:0] porch_pos,
    input  logic [CW-1:0] sync_pos,
    input  logic [CW-1:0] blank_pos,
    output logic          hblank_n,
    output logic          hsync_n,
    output logic          line_stb,
    output logic          half_stb
);
    logic blank_d, sync_d, line_d, half_d;

    // Decode of the current count.
    always_comb begin
        blank_d = (cnt < blank_pos);
        sync_d  = (cnt >= porch_pos) && (cnt < sync_pos);
        line_d  = (cnt == CW'(1));
        half_d  = (cnt == mid_pos);
    end

    // Falling-edge output register, idle until the counter runs.
    always_ff @(negedge clk) begin
        if (!run_q) begin
            hblank_n <= 1'b1;
            hsync_n  <= 1'b1;
            line_stb <= 1'b0;
            half_stb <= 1'b0;
        end else begin
            hblank_n <= ~blank_d;
            hsync_n  <= ~sync_d;
            line_stb <= line_d;
            half_stb <= half_d;
        end
    end

    // R7: the strobes never coincide
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({line_stb, half_stb}));
    // R8: outputs idle right after reset release
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (hblank_n && hsync_n && !line_stb && !half_stb));
endmodule

// File: rtl/hsync_timing_gen.sv
// Top of the horizontal timing generator: a line counter and a
// falling-edge decoder.
// Assumes: 2 <= effective total; the positions are static while rst_n = 1.
module hsync_timing_gen #(
    parameter int unsigned CW = hs_pkg::HS_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          interlace,
    input  logic [CW-1:0] porch_pos,
    input  logic [CW-1:0] sync_pos,
    input  logic [CW-1:0] blank_pos,
    input  logic [CW-1:0] line_len,
    output logic          hblank_n,
    output logic          hsync_n,
    output logic          line_stb,
    output logic          half_stb
);
    logic [CW-1:0] cnt, eff_len, mid_pos;
    logic          run_q;

    hs_line_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .interlace(interlace), .line_len(line_len),
        .cnt(cnt), .eff_len(eff_len), .mid_pos(mid_pos), .run_q(run_q)
    );

    hs_edge_decode #(.CW(CW)) u_dec (
        .clk(clk), .rst_n(rst_n), .run_q(run_q), .cnt(cnt), .mid_pos(mid_pos),
        .porch_pos(porch_pos), .sync_pos(sync_pos), .blank_pos(blank_pos),
        .hblank_n(hblank_n), .hsync_n(hsync_n),
        .line_stb(line_stb), .half_stb(half_stb)
    );
endmodule

// File: tb/hsync_timing_gen_bench.sv
`timescale 1ns/1ps
module hsync_timing_gen_bench;
    localparam int CW = 12;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic interlace = 1'b0;
    logic [CW-1:0] porch_pos = '0, sync_pos = '0, blank_pos = '0, line_len = '0;
    logic hblank_n, hsync_n, line_stb, half_stb;
    int n_tests = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    hsync_timing_gen #(.CW(CW)) u_hsync_timing_gen (
        .clk(clk), .rst_n(rst_n), .interlace(interlace), .porch_pos(porch_pos),
        .sync_pos(sync_pos), .blank_pos(blank_pos), .line_len(line_len),
        .hblank_n(hblank_n), .hsync_n(hsync_n),
        .line_stb(line_stb), .half_stb(half_stb)
    );

    // Compare all four outputs with the expected values for count c (0 = idle).
    task automatic check(input int c, input int p, input string tag);
        logic eb, es, el, eh;
        if (c == 0) begin
            eb = 1; es = 1; el = 0; eh = 0;
        end else begin
            eb = !(c < int'(blank_pos));
            es = !(c >= int'(porch_pos) && c < int'(sync_pos));
            el = (c == 1);
            eh = (c == (p / 2) + 1);
        end
        n_tests++;
        if ({hblank_n, hsync_n, line_stb, half_stb} !== {eb, es, el, eh}) begin
            n_fail++;
            $display("FAIL %s count=%0d got blank/sync/line/half=%b%b%b%b expected %b%b%b%b",
                     tag, c, hblank_n, hsync_n, line_stb, half_stb, eb, es, el, eh);
        end
    endtask

    // One configuration: reset, then sweep more than two lines.
    task automatic run_cfg(input logic il, input int fp, input int se,
                           input int be, input int tot);
        int p;
        int prev;
        @(posedge clk); #1;
        rst_n = 0; interlace = il;
        porch_pos = CW'(fp); sync_pos = CW'(se); blank_pos = CW'(be); line_len = CW'(tot);
        repeat (3) @(posedge clk);
        #3.5 check(0, 0, "R8 reset idle");
        @(posedge clk); #1 rst_n = 1;
        p = il ? tot / 2 : tot;       // R6 effective total
        prev = 0;
        for (int k = 1; k <= 2 * p + 3; k++) begin
            int c;
            c = ((k - 1) % p) + 1;    // R1 count at edge k
            @(posedge clk);
            #1   check(prev, p, "R5 before falling edge");
            #2.5 check(c, p, il ? "R6/R2/R3/R4/R7 interlace" : "R1/R2/R3/R4/R7");
            prev = c;
        end
    endtask

    initial begin
        run_cfg(1'b0, 3, 6, 9, 12);
        run_cfg(1'b0, 1, 3, 4, 7);     // R4 empty front porch, sync at count 1
        run_cfg(1'b0, 2, 3, 2, 2);     // R1 minimal line
        run_cfg(1'b1, 2, 4, 6, 20);    // R6 interlace: P = 10
        run_cfg(1'b1, 2, 3, 4, 11);    // R6 odd total: P = 5
        run_cfg(1'b0, 4, 9, 10, 16);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule